// File: doc/BRIEF.md
# Compare-equal skip controller

This block is the execute-side control for the instruction that compares an 8-bit data-memory operand against the working register and, when the two are equal, skips the next instruction. It decodes the incoming instruction word and forms the operand address from the bank/access select bit, the bank register and an optional indexed-offset pointer. It tests equality with an unsigned subtraction of the working register from the operand, and owns the program counter for this stage.

On a match, the controller squashes the instruction that has already been fetched. It raises a flush output for one cycle when that instruction is one word long, or for two cycles when it is two words long. The program counter advances by one word in each squashed cycle, so execution resumes just after the skipped instruction. New instructions are refused until the flush sequence ends. Every other opcode passes through as a one-cycle, one-word instruction with no skip. No status flag and no data memory location is written.

Top module: `cmpskip_ctrl`

## Requirements
- R1: After reset, `pc` equals the reset address (default 0), `flush` is low and `issue_ready` is high.
- R2: `cmp_decoded` is high exactly when bits 15:9 of `issue_word` equal 7'b0110001. Bit 8 is the bank select and bits 7:0 are the file address.
- R3: When bit 8 is 1, `operand_addr` is {`bank_sel`, file address}.
- R4: When bit 8 is 0 and `index_en` is low, `operand_addr` is {4'h0, f} for f below 0x60 and {4'hF, f} for f of 0x60 and above.
- R5: When bit 8 is 0, `index_en` is high and f is 0x5F or less, `operand_addr` is `index_ptr` + f, modulo 2^12. For f of 0x60 and above the rule of R4 applies.
- R6: In a cycle where an instruction is accepted, `skip_taken` is high exactly when the instruction is the compare and `file_data` equals `wreg` as unsigned values.
- R7: A compare with no match takes one cycle, advances `pc` by 1 and raises no `flush`.
- R8: A match with `next_is_long` low gives exactly one `flush` cycle after the compare cycle. The instruction takes 2 cycles in total and `pc` advances by 2.
- R9: A match with `next_is_long` high gives exactly two consecutive `flush` cycles. The instruction takes 3 cycles in total and `pc` advances by 3.
- R10: While `flush` is high, `issue_ready` is low and `issue_valid`, `issue_word` and the operands have no effect: no extra skip, and no change to the `pc` sequence or the flush length.
- R11: In a cycle with `flush` low and `issue_valid` low, `pc` holds its value.
- R12: An accepted instruction that is not the compare advances `pc` by 1 and never skips, even when `file_data` equals `wreg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | An instruction word is presented for execution |
| issue_ready | output | 1 | Controller can accept an instruction this cycle |
| issue_word | input | 16 | Instruction word being executed |
| bank_sel | input | 4 | Bank register used when the bank select bit is 1 |
| index_en | input | 1 | Indexed literal-offset addressing enabled |
| index_ptr | input | 12 | Base pointer for indexed literal-offset addressing |
| operand_addr | output | 12 | Data-memory address of the operand |
| file_data | input | 8 | Operand read from data memory |
| wreg | input | 8 | Working register value |
| next_is_long | input | 1 | The already-fetched next instruction is two words long |
| cmp_decoded | output | 1 | The word is the compare-and-skip-if-equal opcode |
| skip_taken | output | 1 | Accepted compare matched; a skip begins |
| flush | output | 1 | The fetched word of this cycle must be squashed to a NOP |
| pc | output | 21 | Program counter, in instruction words |

## Verification
The bench sweeps every operand value against itself and against each single-bit neighbour. A comparator that ignored one bit would skip where it must not, and one that used a signed or truncated test would miss a match. It runs each match with short and long followers. A sequencer that mixed up the two lengths would give a flush count or `pc` step off by one word. It drives a fresh matching compare during every flush cycle; a design that did not block issue would skip twice or move `pc` too far. It also sweeps all 128 opcode prefixes with equal operands, and all 256 file addresses under each addressing mode, to catch false decodes and errors at the 0x5F/0x60 access-bank boundary.

// File: rtl/cmpskip_pkg.sv
package cmpskip_pkg;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 7;
    localparam int FILE_W  = 8;
    localparam logic [OPC_W-1:0] OPC_CMP_EQ = 7'b0110001;
    // lowest access-bank address that maps to the special-function area
    localparam logic [FILE_W-1:0] ACCESS_SPLIT = 8'h60;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic              banked;
        logic [FILE_W-1:0] file;
    } instr_t;
endpackage

// File: rtl/cs_decode.sv
module cs_decode
    import cmpskip_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output logic               is_cmp_o,
    output logic               banked_o,
    output logic [FILE_W-1:0]  file_o
);
    instr_t ins;

    always_comb begin
        ins      = instr_t'(word_i);
        is_cmp_o = (ins.opc == OPC_CMP_EQ);
        banked_o = ins.banked;
        file_o   = ins.file;
    end
endmodule

// File: rtl/cs_addr_sel.sv
module cs_addr_sel
    import cmpskip_pkg::*;
#(
    parameter int BANK_W = 4,
    localparam int ADDR_W = BANK_W + FILE_W
) (
    input  logic              banked_i,
    input  logic [FILE_W-1:0] file_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              index_en_i,
    input  logic [ADDR_W-1:0] index_ptr_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic low_half;

    always_comb begin
        low_half = (file_i < ACCESS_SPLIT);
        if (banked_i) begin
            addr_o = {bank_i, file_i};
        end else if (index_en_i && low_half) begin
            addr_o = index_ptr_i + {{BANK_W{1'b0}}, file_i};
        end else if (low_half) begin
            addr_o = {{BANK_W{1'b0}}, file_i};
        end else begin
            addr_o = {{BANK_W{1'b1}}, file_i};
        end
    end
endmodule

// File: rtl/cs_eq_sub.sv
module cs_eq_sub
    import cmpskip_pkg::*;
(
    input  logic [FILE_W-1:0] f_i,
    input  logic [FILE_W-1:0] w_i,
    output logic              eq_o
);
    logic [FILE_W:0] diff;

    always_comb begin
        diff = {1'b0, f_i} - {1'b0, w_i};
        eq_o = (diff == '0);
    end
endmodule

// File: rtl/cs_skip_seq.sv
module cs_skip_seq #(
    parameter int          PC_W     = 21,
    parameter int unsigned RESET_PC = 0,
    parameter int          CNT_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire_i,
    input  logic            hit_i,
    input  logic            next_long_i,
    output logic            ready_o,
    output logic            flush_o,
    output logic [PC_W-1:0] pc_o
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [CNT_W-1:0] left;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.left != '0) begin
            s_d.pc   = s_q.pc + PC_W'(1);
            s_d.left = s_q.left - CNT_W'(1);
        end else if (fire_i) begin
            s_d.pc = s_q.pc + PC_W'(1);
            if (hit_i) begin
                s_d.left = next_long_i ? CNT_W'(2) : CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pc   <= PC_W'(RESET_PC);
            s_q.left <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o = (s_q.left == '0);
    assign flush_o = (s_q.left != '0);
    assign pc_o    = s_q.pc;

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i || flush_o) |=> (pc_o == $past(pc_o) + PC_W'(1)));

    assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_i && !flush_o) |=> $stable(pc_o));

    assert_short_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && hit_i && !next_long_i) |=> flush_o ##1 !flush_o);

    assert_long_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && hit_i && next_long_i) |=> flush_o ##1 flush_o ##1 !flush_o);

    assert_miss_no_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !hit_i) |=> !flush_o);
endmodule

// File: rtl/cmpskip_ctrl.sv
module cmpskip_ctrl
    import cmpskip_pkg::*;
#(
    parameter int          BANK_W   = 4,
    parameter int          PC_W     = 21,
    parameter int unsigned RESET_PC = 0,
    localparam int ADDR_W = BANK_W + FILE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    output logic               issue_ready,
    input  logic [INSTR_W-1:0] issue_word,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic               index_en,
    input  logic [ADDR_W-1:0]  index_ptr,
    output logic [ADDR_W-1:0]  operand_addr,
    input  logic [FILE_W-1:0]  file_data,
    input  logic [FILE_W-1:0]  wreg,
    input  logic               next_is_long,
    output logic               cmp_decoded,
    output logic               skip_taken,
    output logic               flush,
    output logic [PC_W-1:0]    pc
);
    logic              banked;
    logic [FILE_W-1:0] file_a;
    logic              equal;
    logic              fire;

    cs_decode u_dec (
        .word_i   (issue_word),
        .is_cmp_o (cmp_decoded),
        .banked_o (banked),
        .file_o   (file_a)
    );

    cs_addr_sel #(.BANK_W(BANK_W)) u_addr (
        .banked_i    (banked),
        .file_i      (file_a),
        .bank_i      (bank_sel),
        .index_en_i  (index_en),
        .index_ptr_i (index_ptr),
        .addr_o      (operand_addr)
    );

    cs_eq_sub u_eq (
        .f_i  (file_data),
        .w_i  (wreg),
        .eq_o (equal)
    );

    assign fire       = issue_valid && issue_ready;
    assign skip_taken = fire && cmp_decoded && equal;

    cs_skip_seq #(.PC_W(PC_W), .RESET_PC(RESET_PC), .CNT_W(2)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .hit_i       (cmp_decoded && equal),
        .next_long_i (next_is_long),
        .ready_o     (issue_ready),
        .flush_o     (flush),
        .pc_o        (pc)
    );

    assert_skip_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_taken |-> (file_data == wreg));

    assert_skip_opcode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        skip_taken |-> (issue_word[15:9] == 7'b0110001));

    assert_flush_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !skip_taken);

    assert_banked_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_word[8] |-> (operand_addr == {bank_sel, issue_word[7:0]}));
endmodule

// File: tb/cmpskip_ctrl_bench.sv
module cmpskip_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [15:0] issue_word = '0;
    logic [3:0]  bank_sel = '0;
    logic        index_en = 1'b0;
    logic [11:0] index_ptr = '0;
    logic [11:0] operand_addr;
    logic [7:0]  file_data = '0;
    logic [7:0]  wreg = '0;
    logic        next_is_long = 1'b0;
    logic        cmp_decoded;
    logic        skip_taken;
    logic        flush;
    logic [20:0] pc;

    int checks = 0;
    int failures = 0;
    logic [20:0] exp_pc = '0;

    always #10 clk = ~clk;

    cmpskip_ctrl u_cmpskip_ctrl (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_word(issue_word), .bank_sel(bank_sel), .index_en(index_en),
        .index_ptr(index_ptr), .operand_addr(operand_addr), .file_data(file_data),
        .wreg(wreg), .next_is_long(next_is_long), .cmp_decoded(cmp_decoded),
        .skip_taken(skip_taken), .flush(flush), .pc(pc)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] model_addr(logic [15:0] w, logic [3:0] b,
                                               logic ie, logic [11:0] ip);
        logic [7:0] f;
        f = w[7:0];
        if (w[8]) return {b, f};
        if (ie && f <= 8'h5F) return ip + {4'h0, f};
        if (f < 8'h60) return {4'h0, f};
        return {4'hF, f};
    endfunction

    task automatic run_instr(input logic [15:0] word, input logic [7:0] fd,
                             input logic [7:0] wv, input logic lng, input bit junk);
        bit is_c, hit;
        int n, exp_n;
        logic [11:0] ea;
        @(negedge clk);
        issue_valid = 1'b1; issue_word = word; file_data = fd; wreg = wv;
        next_is_long = lng;
        is_c = (word[15:9] == 7'b0110001);
        hit = is_c && (fd == wv);
        ea = model_addr(word, bank_sel, index_en, index_ptr);
        #5;
        check(issue_ready == 1'b1, "R10 ready before issue", 32'(issue_ready), 1);
        check(cmp_decoded == is_c, "R2 decode", 32'(cmp_decoded), 32'(is_c));
        check(skip_taken == hit, "R6/R12 skip_taken", 32'(skip_taken), 32'(hit));
        check(operand_addr == ea, "R3/R4/R5 operand_addr", 32'(operand_addr), 32'(ea));
        @(posedge clk);
        @(negedge clk);
        if (junk) begin
            issue_valid = 1'b1;
            issue_word = {7'b0110001, 1'b1, 8'h11};
            file_data = 8'h5A; wreg = 8'h5A; next_is_long = ~lng;
        end else begin
            issue_valid = 1'b0;
        end
        n = 0;
        while (flush === 1'b1 && n < 6) begin
            n++;
            check(issue_ready == 1'b0, "R10 ready low in flush", 32'(issue_ready), 0);
            check(skip_taken == 1'b0, "R10 no skip in flush", 32'(skip_taken), 0);
            @(posedge clk);
            @(negedge clk);
        end
        issue_valid = 1'b0;
        exp_n = hit ? (lng ? 2 : 1) : 0;
        check(n == exp_n, hit ? (lng ? "R9 flush count" : "R8 flush count")
                              : (is_c ? "R7 flush count" : "R12 flush count"),
              32'(n), 32'(exp_n));
        exp_pc = exp_pc + 21'(1 + exp_n);
        check(pc == exp_pc, hit ? (lng ? "R9 pc" : "R8 pc")
                                : (is_c ? "R7 pc" : "R12 pc"),
              32'(pc), 32'(exp_pc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #5;
        // R1 reset state
        check(pc == 21'd0, "R1 pc reset", 32'(pc), 0);
        check(flush == 1'b0, "R1 flush reset", 32'(flush), 0);
        check(issue_ready == 1'b1, "R1 ready reset", 32'(issue_ready), 1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R11 idle cycles hold pc
        repeat (3) @(negedge clk);
        check(pc == exp_pc, "R11 idle hold", 32'(pc), 32'(exp_pc));

        // R6/R7/R8/R9: operand sweep vs itself and single-bit neighbours
        for (int f = 0; f < 256; f++) begin
            run_instr({7'b0110001, 1'b1, 8'h20}, 8'(f), 8'(f), f[0], 1'b0);
            run_instr({7'b0110001, 1'b1, 8'h20}, 8'(f), 8'(f), ~f[0], f[1]);
            for (int k = 0; k < 8; k++)
                run_instr({7'b0110001, 1'b1, 8'h20}, 8'(f), 8'(f) ^ (8'h1 << k), f[0], 1'b0);
        end

        // R10: new matching compare held during flush, both follower lengths
        run_instr({7'b0110001, 1'b0, 8'h05}, 8'hC3, 8'hC3, 1'b1, 1'b1);
        run_instr({7'b0110001, 1'b0, 8'h05}, 8'h00, 8'h00, 1'b0, 1'b1);

        // R2/R12: every opcode prefix with equal operands
        for (int op = 0; op < 128; op++)
            run_instr({7'(op), 1'b1, 8'h44}, 8'h77, 8'h77, 1'b0, 1'b0);

        // R3/R4/R5: address modes over all file addresses
        for (int m = 0; m < 3; m++) begin
            bank_sel  = 4'(3 + m * 5);
            index_en  = (m != 0);
            index_ptr = (m == 2) ? 12'hFD0 : 12'h1A0;
            for (int f = 0; f < 256; f++) begin
                run_instr({7'b0110001, 1'b0, 8'(f)}, 8'h01, 8'h02, 1'b0, 1'b0);
                run_instr({7'b0110001, 1'b1, 8'(f)}, 8'h01, 8'h02, 1'b0, 1'b0);
            end
        end

        // R11 again after activity
        repeat (4) @(negedge clk);
        check(pc == exp_pc, "R11 idle hold late", 32'(pc), 32'(exp_pc));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule